// File: doc/BRIEF.md
# Bus Memory Block Write-Protect Guard

This unit sits between the system bus and the storage array of a memory board. The board's address window is split into fixed-size blocks, and each block has one protect flag. Two dedicated bus strobes change a flag: a protect strobe sets it and an unprotect strobe clears it. A strobe acts only on the block that the address bus points at, and only when that address falls inside this board's window. A write request aimed at a protected block never reaches the array.

The unit also drives an active-low status line. The line goes low while the bus addresses a protected block on this board, so an indicator lamp or a monitoring card can show that a write there would be lost. Reads are not gated by the unit in any way. Block size, block count, address width and the board's base tag are all parameters.

Top module: `wp_bank_guard`

## Requirements
- R1: While `rstN` is low, every protect flag is cleared. After reset, every block is unprotected: an on-board write passes and `protStatusN` reads 1.
- R2: The board is selected when `busAddr[ADDR_W-1:BLOCK_BITS+IDX_W]` equals the low bits of `BOARD_BASE`, where `IDX_W` = clog2(`NUM_BLOCKS`). With the defaults (16-bit address, 4 KiB blocks, 2 blocks, base 3) the board spans 0x6000 to 0x7FFF. For an off-board address, `arrayWrEn` is 0 and `protStatusN` is 1, and both strobes leave every flag unchanged.
- R3: The addressed block is `busAddr[BLOCK_BITS +: IDX_W]`. With the defaults, address bit 12 picks block 0 or block 1.
- R4: When `protStrobe` (active high) is 1 at a rising clock edge with an on-board address, the addressed block's flag is set from that edge on.
- R5: When `unprotStrobe` (active high) is 1 at a rising clock edge with an on-board address, and `protStrobe` is 0, the addressed block's flag is cleared from that edge on.
- R6: When both strobes are 1 in the same cycle, protection wins and the flag ends up set.
- R7: `arrayWrEn` is combinationally 1 exactly when `memWrReq` is 1, the address is on-board, and the addressed block's flag is clear.
- R8: A write request in the same cycle as a strobe is judged by the flag value from before that cycle's clock edge.
- R9: `protStatusN` is combinationally 0 exactly when the address is on-board and the addressed block's flag is set. It does not depend on `memWrReq`.
- R10: A strobe changes only the addressed block's flag. The flags of the other blocks keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Bus address |
| protStrobe | input | 1 | Sets the addressed block's flag, active high |
| unprotStrobe | input | 1 | Clears the addressed block's flag, active high |
| memWrReq | input | 1 | Write request from the bus |
| arrayWrEn | output | 1 | Gated write enable to the storage array |
| protStatusN | output | 1 | Low while a protected on-board block is addressed |

## Verification
A flag change and a gated write can occur in the same cycle. The bench provokes this by asserting a protect or unprotect strobe together with `memWrReq` on the same block. It then expects the write enable to follow the old flag in that cycle and the new flag in the next cycle. The case where both strobes are active at once is driven in the same way, and the winner is judged through the write enable and status line in the following cycle. A behavioural model holds an array of flags and predicts both outputs every cycle.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  // Per-cycle requests from the address decode to the flag datapath.
  typedef struct packed {
    logic boardHit;   // address inside this board's window
    logic setReq;     // protect strobe qualified by board hit
    logic clrReq;     // unprotect strobe, qualified, loses to protect
    logic wrReq;      // write request qualified by board hit
  } wpgStrobes_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLOCK_BITS = 12,
  parameter int NUM_BLOCKS = 2,
  parameter logic [ADDR_W-1:0] BOARD_BASE = 3
) (
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  protStrobe,
  input  logic                  unprotStrobe,
  input  logic                  memWrReq,
  output wpgStrobes_t           strobes,
  output logic [NUM_BLOCKS-1:0] blockSel
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);
  localparam int TAG_LO = BLOCK_BITS + IDX_W;
  localparam int TAG_W = ADDR_W - TAG_LO;

  logic boardHit;
  logic unused_addrLow;

  assign unused_addrLow = ^busAddr[BLOCK_BITS-1:0];
  assign boardHit = (busAddr[ADDR_W-1:TAG_LO] == BOARD_BASE[TAG_W-1:0]);

  generate
    if (NUM_BLOCKS == 1) begin : g_single
      assign blockSel = boardHit;
    end else begin : g_multi
      logic [IDX_W-1:0] blockIdx;
      assign blockIdx = busAddr[BLOCK_BITS +: IDX_W];
      always_comb begin
        blockSel = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
          if (boardHit && (blockIdx == IDX_W'(i))) blockSel[i] = 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    strobes.boardHit = boardHit;
    strobes.setReq   = boardHit & protStrobe;
    strobes.clrReq   = boardHit & unprotStrobe & ~protStrobe;
    strobes.wrReq    = boardHit & memWrReq;
  end
endmodule

// File: rtl/wpg_flags.sv
module wpg_flags
  import wpg_pkg::*;
#(
  parameter int NUM_BLOCKS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wpgStrobes_t           strobes,
  input  logic [NUM_BLOCKS-1:0] blockSel,
  output logic [NUM_BLOCKS-1:0] flagVec,
  output logic                  arrayWrEn,
  output logic                  protStatusN
);
  logic hitProtected;

  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagVec[b] <= 1'b0;
        end else if (blockSel[b]) begin
          if (strobes.setReq) flagVec[b] <= 1'b1;
          else if (strobes.clrReq) flagVec[b] <= 1'b0;
        end
      end
    end
  endgenerate

  // Uses the registered flags, so a same-cycle strobe does not affect this.
  assign hitProtected = |(flagVec & blockSel);
  assign arrayWrEn    = strobes.wrReq & ~hitProtected;
  assign protStatusN  = ~(strobes.boardHit & hitProtected);
endmodule

// File: rtl/wp_bank_guard.sv
module wp_bank_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLOCK_BITS = 12,
  parameter int NUM_BLOCKS = 2,
  parameter logic [ADDR_W-1:0] BOARD_BASE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              protStrobe,
  input  logic              unprotStrobe,
  input  logic              memWrReq,
  output logic              arrayWrEn,
  output logic              protStatusN
);
  wpgStrobes_t           strobes;
  logic [NUM_BLOCKS-1:0] blockSel;
  logic [NUM_BLOCKS-1:0] flagVec;

  wpg_ctrl #(
    .ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS),
    .NUM_BLOCKS(NUM_BLOCKS), .BOARD_BASE(BOARD_BASE)
  ) u_ctrl (
    .busAddr(busAddr), .protStrobe(protStrobe), .unprotStrobe(unprotStrobe),
    .memWrReq(memWrReq), .strobes(strobes), .blockSel(blockSel)
  );

  wpg_flags #(.NUM_BLOCKS(NUM_BLOCKS)) u_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes), .blockSel(blockSel),
    .flagVec(flagVec), .arrayWrEn(arrayWrEn), .protStatusN(protStatusN)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int NUM_BLOCKS = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  protStrobe,
  input logic                  unprotStrobe,
  input logic                  memWrReq,
  input logic                  arrayWrEn,
  input logic                  protStatusN,
  input logic                  boardHit,
  input logic [NUM_BLOCKS-1:0] blockSel,
  input logic [NUM_BLOCKS-1:0] flagVec
);
  // R4, R6: protect strobe on board leaves the addressed flag set
  a_r4_prot_sets: assert property (@(posedge clk) disable iff (!rstN)
    (protStrobe && boardHit) |=> ((flagVec & $past(blockSel)) != '0));

  // R5: unprotect alone clears the addressed flag
  a_r5_unprot_clears: assert property (@(posedge clk) disable iff (!rstN)
    (unprotStrobe && !protStrobe && boardHit) |=> ((flagVec & $past(blockSel)) == '0));

  // R2: off-board cycles leave all flags unchanged
  a_r2_offboard_stable: assert property (@(posedge clk) disable iff (!rstN)
    !boardHit |=> $stable(flagVec));

  // R7: write enable needs a request, a board hit and a clear flag
  a_r7_write_gate: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrEn |-> (memWrReq && boardHit && ((flagVec & blockSel) == '0)));

  // R9: status low only when a protected on-board block is addressed
  a_r9_status: assert property (@(posedge clk) disable iff (!rstN)
    !protStatusN |-> (boardHit && ((flagVec & blockSel) != '0)));

  // R3: at most one block is selected
  a_r3_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blockSel));
endmodule

bind wp_bank_guard wpg_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rstN(rstN), .protStrobe(protStrobe), .unprotStrobe(unprotStrobe),
  .memWrReq(memWrReq), .arrayWrEn(arrayWrEn), .protStatusN(protStatusN),
  .boardHit(strobes.boardHit), .blockSel(blockSel), .flagVec(flagVec)
);

// File: tb/wp_bank_guard_bench.sv
`timescale 1ns/1ps
module wp_bank_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic protStrobe = 1'b0, unprotStrobe = 1'b0, memWrReq = 1'b0;
  logic arrayWrEn, protStatusN;

  int tests = 0;
  int fails = 0;
  bit model [2];
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_bank_guard u_wp_bank_guard (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .protStrobe(protStrobe),
    .unprotStrobe(unprotStrobe), .memWrReq(memWrReq),
    .arrayWrEn(arrayWrEn), .protStatusN(protStatusN)
  );

  function automatic bit onBoard(input logic [15:0] a);
    return a[15:13] == 3'd3;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive after negedge, check combinational outputs, then
  // advance the model at the rising edge.
  task automatic step(input string req, input logic [15:0] a,
                      input bit p, input bit u, input bit w);
    bit hit, prot;
    int idx;
    @(negedge clk);
    busAddr = a; protStrobe = p; unprotStrobe = u; memWrReq = w;
    #1;
    hit = onBoard(a);
    idx = int'(a[12]);
    prot = hit && model[idx];
    check(req, arrayWrEn, w && hit && !prot, "arrayWrEn");
    check(req, protStatusN, !prot, "protStatusN");
    @(posedge clk);
    if (hit) begin
      if (p) model[idx] = 1'b1;
      else if (u) model[idx] = 1'b0;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model[0] = 1'b0; model[1] = 1'b0;
    busAddr = 16'h6000; memWrReq = 1'b1;
    #1;
    check("R1", protStatusN, 1'b1, "status in reset");
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    step("R1", 16'h6000, 0, 0, 1);          // unprotected after reset
    step("R1", 16'h7FFF, 0, 0, 1);
    step("R2", 16'h2000, 1, 0, 1);          // off-board protect ignored
    step("R2", 16'h3000, 1, 0, 0);
    step("R2", 16'h6000, 0, 0, 1);          // block 0 still writable
    step("R2", 16'h7000, 0, 0, 1);          // block 1 still writable
    step("R4", 16'h7123, 1, 0, 0);          // protect block 1 (bit 12 = 1)
    step("R4", 16'h7FFF, 0, 0, 1);          // blocked, status low
    step("R9", 16'h7FFF, 0, 0, 0);          // status without write
    step("R10", 16'h6ABC, 0, 0, 1);         // block 0 unaffected
    step("R3", 16'h6FFF, 0, 0, 1);          // top of block 0
    step("R8", 16'h6010, 1, 0, 1);          // write passes in protect cycle
    step("R8", 16'h6010, 0, 0, 1);          // then blocked
    step("R2", 16'hE000, 0, 1, 1);          // off-board unprotect ignored
    step("R2", 16'h6000, 0, 0, 1);
    step("R8", 16'h7000, 0, 1, 1);          // blocked in unprotect cycle
    step("R5", 16'h7000, 0, 0, 1);          // then passes
    step("R10", 16'h6000, 0, 0, 1);         // block 0 still protected
    step("R6", 16'h7800, 1, 1, 0);          // both strobes: set wins
    step("R6", 16'h7800, 0, 0, 1);
    step("R5", 16'h6000, 0, 1, 0);          // clear block 0
    step("R5", 16'h6000, 0, 0, 1);
    step("R10", 16'h7000, 0, 0, 1);         // block 1 still protected
    step("R6", 16'h6400, 1, 1, 1);          // both + write, old flag clear
    step("R6", 16'h6400, 0, 0, 1);
    step("R9", 16'h1000, 0, 0, 0);          // off-board status high
    step("R7", 16'h6400, 0, 0, 0);          // no request, no enable
    @(negedge clk); rstN = 1'b0;            // reset mid-run clears flags
    @(negedge clk); rstN = 1'b1;
    model[0] = 1'b0; model[1] = 1'b0;
    step("R1", 16'h6000, 0, 0, 1);
    step("R1", 16'h7000, 0, 0, 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule